// File: doc/BRIEF.md
# LIN Controller Mode Sequencer

This block holds the mode control register of a LIN/UART controller and the small state machine behind it. Software reaches the register through a byte-wide interface with an address compare, a write strobe, a read strobe and registered read data. Two implemented control bits move the controller between three modes: reset, wake-up and operation. The upper six bits are not implemented.

A separate status output reports the mode a fixed number of cycles after each accepted write. A busy flag stays high while that report is pending, so software writes, waits for the status to match, then writes again. Writes are refused in five cases: the address does not match, the LIN-mode qualifier is low, a frame transmission is starting, a status update is still pending, or self-test mode is selected but not yet reported ready. While the qualifier is low, the register and both mode outputs are held at reset.

Top module: `lin_mode_seq`

## Requirements
- R1: After a synchronous reset, `mode` and `mode_stat` are 2'b00, `upd_busy` is 0 and a read of the register returns 8'h00.
- R2: Read data appears one clock after a read strobe to the register's address and carries the two control bits in bits 1:0. Bits 7:2 always read as zero, whatever value was written to them.
- R3: An accepted write with bit 0 clear puts the controller in reset mode (2'b00), whatever bit 1 holds (02H gives 2'b00).
- R4: An accepted write of 01H gives wake-up mode (2'b01) and 03H gives operation mode (2'b11). `mode` takes the new value at the clock edge that accepts the write.
- R5: While `lin_en` is low, writes are ignored. At the next edge, `mode` and `mode_stat` become 2'b00, the register reads as 0 and any pending status update is cancelled.
- R6: A write presented while `tx_busy` is high is ignored.
- R7: While `st_mode` is high and `st_ready` is low, writes are ignored. Once `st_ready` is high, writes are accepted again.
- R8: `mode_stat` takes the mode set by an accepted write exactly 4 clock edges after the accepting edge, and holds its old value before then.
- R9: `upd_busy` is high for the 4 cycles that follow an accepted write. Any write presented while it is high is ignored.
- R10: `mode` never holds the unused code 2'b10.
- R11: A write or read strobe with an address other than the register's address leaves the mode unchanged and returns read data 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW (4) | Register address; the register sits at REG_ADDR |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| lin_en | input | 1 | LIN-mode qualifier; the register has effect only while this is high |
| tx_busy | input | 1 | Frame transmission start flag; blocks writes |
| st_mode | input | 1 | Self-test mode selected |
| st_ready | input | 1 | Self-test entry reported complete |
| mode | output | 2 | Current mode: 00 reset, 01 wake-up, 11 operation |
| mode_stat | output | 2 | Mode status, delayed after each accepted write |
| upd_busy | output | 1 | A status update is pending |

## Verification
`mode` is due at the edge that accepts a write. Read data is due one edge after the read strobe. `mode_stat` is due four edges after the accepting edge, and `upd_busy` covers the edges between. The bench keeps its reference model in step with these timings by keeping a queue of pending status updates, each tagged with the cycle it is due. It compares every output on each falling edge, half a period after the edge that produced it. Directed checks also sample the status on the third and fourth edges after a write, to pin down the exact cycle of the change.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    LM_RESET = 2'b00,
    LM_WAKE  = 2'b01,
    LM_OPER  = 2'b11
  } lin_mode_e;

  localparam int CTRL_W = 2;

  // bit 0 releases reset, bit 1 picks operation over wake-up
  function automatic lin_mode_e decode_ctrl(input logic [CTRL_W-1:0] c);
    if (!c[0])     return LM_RESET;
    else if (c[1]) return LM_OPER;
    else           return LM_WAKE;
  endfunction
endpackage

// File: rtl/lin_mode_wrgate.sv
module lin_mode_wrgate #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int CW       = 2,
  parameter logic [AW-1:0] REG_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [CW-1:0] wr_bits,
  input  logic          lin_en,
  input  logic          tx_busy,
  input  logic          st_mode,
  input  logic          st_ready,
  input  logic          upd_busy,
  output logic          accept,
  output logic [DW-1:0] rd_data
);
  localparam int PAD_W = DW - CW;

  logic          hit;
  logic          st_block;
  logic [CW-1:0] ctrl_q;

  assign hit      = (addr == REG_ADDR);
  assign st_block = st_mode & ~st_ready;
  assign accept   = hit & wr_en & lin_en & ~tx_busy & ~upd_busy & ~st_block;

  always_ff @(posedge clk) begin
    if (rst || !lin_en) ctrl_q <= '0;
    else if (accept)    ctrl_q <= wr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst)                rd_data <= '0;
    else if (hit && rd_en)  rd_data <= {{PAD_W{1'b0}}, ctrl_q};
    else                    rd_data <= '0;
  end
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lin_en,
  input  logic              accept,
  input  logic [CTRL_W-1:0] wr_bits,
  output lin_mode_e         mode_q
);
  always_ff @(posedge clk) begin
    if (rst || !lin_en) mode_q <= LM_RESET;
    else if (accept)    mode_q <= decode_ctrl(wr_bits);
  end
endmodule

// File: rtl/lin_mode_stat.sv
module lin_mode_stat
  import lin_mode_pkg::*;
#(
  parameter int DELAY = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lin_en,
  input  logic      accept,
  input  lin_mode_e cur_mode,
  output lin_mode_e stat_q,
  output logic      busy
);
  localparam int CNTW = $clog2(DELAY + 1);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !lin_en) begin
      cnt_q  <= '0;
      stat_q <= LM_RESET;
    end else if (accept) begin
      cnt_q  <= CNTW'(DELAY);
    end else if (cnt_q == CNTW'(1)) begin
      cnt_q  <= '0;
      stat_q <= cur_mode;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lin_mode_seq.sv
module lin_mode_seq
  import lin_mode_pkg::*;
#(
  parameter int AW       = 4,
  parameter logic [AW-1:0] REG_ADDR = 4'h6,
  parameter int STAT_DELAY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          lin_en,
  input  logic          tx_busy,
  input  logic          st_mode,
  input  logic          st_ready,
  output logic [1:0]    mode,
  output logic [1:0]    mode_stat,
  output logic          upd_busy
);
  lin_mode_e mode_q;
  lin_mode_e stat_q;
  logic      accept;
  logic      busy;
  logic      unused_rsv;

  // reserved write bits are dropped here
  assign unused_rsv = ^wr_data[7:CTRL_W];

  lin_mode_wrgate #(.AW(AW), .DW(8), .CW(CTRL_W), .REG_ADDR(REG_ADDR)) u_gate (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_bits(wr_data[CTRL_W-1:0]), .lin_en(lin_en), .tx_busy(tx_busy),
    .st_mode(st_mode), .st_ready(st_ready), .upd_busy(busy),
    .accept(accept), .rd_data(rd_data)
  );

  lin_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .lin_en(lin_en), .accept(accept),
    .wr_bits(wr_data[CTRL_W-1:0]), .mode_q(mode_q)
  );

  lin_mode_stat #(.DELAY(STAT_DELAY)) u_stat (
    .clk(clk), .rst(rst), .lin_en(lin_en), .accept(accept),
    .cur_mode(mode_q), .stat_q(stat_q), .busy(busy)
  );

  assign mode      = mode_q;
  assign mode_stat = stat_q;
  assign upd_busy  = busy;
endmodule

// File: rtl/lin_mode_seq_chk.sv
module lin_mode_seq_chk #(
  parameter int AW = 4,
  parameter logic [AW-1:0] REG_ADDR = 4'h6
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic          lin_en,
  input logic          tx_busy,
  input logic          st_mode,
  input logic          st_ready,
  input logic [1:0]    mode,
  input logic [1:0]    mode_stat,
  input logic          upd_busy
);
  logic wr_try;
  assign wr_try = (addr == REG_ADDR) && wr_en && lin_en;

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:2] == 6'b0);

  p_lin_off_r5: assert property (@(posedge clk) disable iff (rst)
    !lin_en |=> (mode == 2'b00) && (mode_stat == 2'b00) && !upd_busy);

  p_tx_block_r6: assert property (@(posedge clk) disable iff (rst)
    (lin_en && tx_busy) |=> mode == $past(mode));

  p_selftest_block_r7: assert property (@(posedge clk) disable iff (rst)
    (lin_en && st_mode && !st_ready) |=> mode == $past(mode));

  p_stat_match_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(upd_busy) && lin_en) |-> mode_stat == mode);

  p_busy_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_try && !tx_busy && !upd_busy && !(st_mode && !st_ready)) |=> upd_busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (lin_en && upd_busy) |=> mode == $past(mode));

  p_no_code10_r10: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b10);

  p_miss_rd_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == REG_ADDR) |=> rd_data == 8'h00);
endmodule

bind lin_mode_seq lin_mode_seq_chk #(.AW(AW), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .lin_en(lin_en), .tx_busy(tx_busy), .st_mode(st_mode),
  .st_ready(st_ready), .mode(mode), .mode_stat(mode_stat), .upd_busy(upd_busy)
);

// File: tb/tb_lin_mode_seq.sv
`timescale 1ns/1ps
module tb_lin_mode_seq;
  localparam logic [3:0] RA = 4'h6;
  localparam int DLY = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       lin_en = 1'b0, tx_busy = 1'b0, st_mode = 1'b0, st_ready = 1'b0;
  logic [1:0] mode, mode_stat;
  logic       upd_busy;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lin_mode_seq dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .lin_en(lin_en), .tx_busy(tx_busy),
    .st_mode(st_mode), .st_ready(st_ready), .mode(mode),
    .mode_stat(mode_stat), .upd_busy(upd_busy)
  );

  // behavioural reference model
  logic [1:0] m_ctrl, m_mode, m_stat;
  logic [7:0] m_rd;
  logic       m_busy, m_pre_busy, m_hit;
  int         cyc = 0;
  int         q_due[$];
  logic [1:0] q_val[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ctrl = 0; m_mode = 0; m_stat = 0; m_rd = 0;
      q_due.delete(); q_val.delete();
    end else begin
      m_pre_busy = (q_due.size() != 0);
      m_hit = (addr == RA);
      m_rd = (m_hit && rd_en) ? {6'b0, m_ctrl} : 8'h00;
      if (!lin_en) begin
        m_ctrl = 0; m_mode = 0; m_stat = 0;
        q_due.delete(); q_val.delete();
      end else begin
        if (q_due.size() != 0 && q_due[0] == cyc) begin
          m_stat = q_val[0];
          void'(q_due.pop_front()); void'(q_val.pop_front());
        end
        if (m_hit && wr_en && !tx_busy && !m_pre_busy && !(st_mode && !st_ready)) begin
          m_ctrl = wr_data[1:0];
          m_mode = !wr_data[0] ? 2'b00 : (wr_data[1] ? 2'b11 : 2'b01);
          q_due.push_back(cyc + DLY);
          q_val.push_back(m_mode);
        end
      end
    end
    m_busy = (q_due.size() != 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(rd_data == m_rd, "R2 rd_data", rd_data, m_rd);
    chk(mode == m_mode, "R4 mode", mode, m_mode);
    chk(mode_stat == m_stat, "R8 mode_stat", mode_stat, m_stat);
    chk(upd_busy == m_busy, "R9 upd_busy", upd_busy, m_busy);
    chk(mode != 2'b10, "R10 mode code", mode, 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!rst) compare_all();
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; addr = RA;
  endtask

  task automatic wr(input logic [7:0] d);
    addr = RA; wr_en = 1; wr_data = d;
    tick();
    idle();
  endtask

  task automatic rd(output logic [7:0] v);
    addr = RA; rd_en = 1;
    tick();
    v = rd_data;
    idle();
  endtask

  task automatic settle();
    for (int i = 0; i < DLY + 1; i++) tick();
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(mode == 2'b00, "R1 mode", mode, 0);
    chk(mode_stat == 2'b00, "R1 stat", mode_stat, 0);
    chk(upd_busy == 1'b0, "R1 busy", upd_busy, 0);
    rd(v); chk(v == 8'h00, "R1 read", v, 0);

    lin_en = 1;
    tick();
    // R4 wake-up, R8/R9 timing
    wr(8'h01);
    chk(mode == 2'b01, "R4 wake", mode, 1);
    chk(upd_busy, "R9 busy after accept", upd_busy, 1);
    chk(mode_stat == 2'b00, "R8 stat old", mode_stat, 0);
    tick(); tick(); tick();
    chk(mode_stat == 2'b00, "R8 stat at edge 3", mode_stat, 0);
    chk(upd_busy, "R9 busy at edge 3", upd_busy, 1);
    tick();
    chk(mode_stat == 2'b01, "R8 stat at edge 4", mode_stat, 1);
    chk(!upd_busy, "R9 busy clear", upd_busy, 0);
    rd(v); chk(v == 8'h01, "R2 read 01", v, 1);

    // R2 reserved bits, R4 operation
    wr(8'hFF); settle();
    chk(mode == 2'b11, "R4 oper", mode, 3);
    rd(v); chk(v == 8'h03, "R2 reserved zero", v, 3);

    // R3 bit0 clear gives reset
    wr(8'h02); settle();
    chk(mode == 2'b00, "R3 02h reset", mode, 0);
    chk(mode_stat == 2'b00, "R3 stat", mode_stat, 0);

    // R9 write during busy ignored
    wr(8'h03);
    wr(8'h01);
    settle();
    chk(mode == 2'b11, "R9 busy write dropped", mode, 3);
    chk(mode_stat == 2'b11, "R9 stat", mode_stat, 3);

    // R6 tx busy
    tx_busy = 1; wr(8'h01); tx_busy = 0;
    chk(!upd_busy, "R6 no busy", upd_busy, 0);
    settle();
    chk(mode == 2'b11, "R6 mode held", mode, 3);

    // R11 other address
    addr = 4'h2; wr_en = 1; wr_data = 8'h01; tick(); idle();
    chk(mode == 2'b11, "R11 miss write", mode, 3);
    addr = 4'h2; rd_en = 1; tick(); v = rd_data; idle();
    chk(v == 8'h00, "R11 miss read", v, 0);

    // R7 self-test
    st_mode = 1; st_ready = 0; wr(8'h01); settle();
    chk(mode == 2'b11, "R7 not ready", mode, 3);
    st_ready = 1; wr(8'h01); settle();
    chk(mode == 2'b01, "R7 ready", mode, 1);
    st_mode = 0; st_ready = 0;

    // R5 qualifier low
    wr(8'h03);
    lin_en = 0; tick();
    chk(mode == 2'b00, "R5 mode reset", mode, 0);
    chk(mode_stat == 2'b00, "R5 stat reset", mode_stat, 0);
    chk(!upd_busy, "R5 pending cancelled", upd_busy, 0);
    wr(8'h03); settle();
    chk(mode == 2'b00, "R5 write ignored", mode, 0);
    rd(v); chk(v == 8'h00, "R5 read zero", v, 0);
    lin_en = 1; tick();
    rd(v); chk(v == 8'h00, "R5 ctrl cleared", v, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule